// File: doc/BRIEF.md
# Window Monitor Comparator

This block checks each converted sample against a window made of a lower bound and an upper bound and reports whether the sample satisfies the selected condition. A three-bit mode input picks the condition. The choices are off, above the lower bound, below the upper bound, strictly inside the window, and an inverted window in which the two bounds trade roles. The three remaining codes are reserved and never report a match. Every comparison is strict, so a sample equal to a bound never matches.

Samples arrive on a valid/ready input stream. The block never applies back-pressure: `res_ready` is high at all times, so a sample is taken on every clock edge where `res_valid` is high. When the differential flag is set, samples and bounds are two's-complement values, because a differential conversion can be negative. Otherwise they are unsigned. For each accepted sample the block gives a one-cycle registered match pulse. It also drives a sticky interrupt flag that stays set until a clear input is asserted.

Top module: `wmon_top`

## Requirements
- R1: While reset is active and on the first cycle after it, `match_o` and `irq_o` are 0.
- R2: Mode code 0 (off) never produces a match, whatever the sample and the bounds.
- R3: Mode code 1 matches only when the sample is strictly greater than `thr_lo`.
- R4: Mode code 2 matches only when the sample is strictly less than `thr_hi`.
- R5: Mode code 3 matches only when `thr_lo` < sample < `thr_hi`, with both inequalities strict.
- R6: Mode code 4 matches only when `thr_hi` < sample < `thr_lo`, with both inequalities strict.
- R7: Mode codes 5, 6 and 7 never produce a match.
- R8: A sample is evaluated only on an edge where `res_valid` is high. `match_o` is high for exactly the one cycle after that edge when the condition holds, and it is low after any edge where `res_valid` is low.
- R9: `irq_o` becomes 1 in the same cycle that `match_o` rises, and it stays 1 until it is cleared.
- R10: `irq_clr` high at an edge clears `irq_o`, unless a matching sample is accepted at that same edge, in which case `irq_o` stays set.
- R11: With `diff_en`=1 the sample and both bounds are compared as two's-complement signed values (for 12 bits, 12'hFFF is -1). With `diff_en`=0 they are compared as unsigned values.
- R12: `res_ready` is 1 on every cycle, so no sample is ever held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | A sample is present on `res_data` |
| res_ready | output | 1 | Always high; the block accepts every sample |
| res_data | input | DW | Conversion sample |
| diff_en | input | 1 | 1: signed comparison, 0: unsigned comparison |
| thr_lo | input | DW | Lower bound |
| thr_hi | input | DW | Upper bound |
| mode | input | 3 | Condition select, codes 0 to 7 |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| match_o | output | 1 | Registered one-cycle match pulse |
| irq_o | output | 1 | Sticky match interrupt flag |

## Verification
The assertions assume that `mode`, `diff_en`, both bounds and `res_data` are stable and known at each edge where `res_valid` is high. They also assume that the block sees no reset glitch in the middle of an evaluation. The bench meets these assumptions by changing every input only on the falling clock edge. It holds the bounds and the mode steady while a sample is presented, and it drops `res_valid` between vectors so that the idle and pulse-width checks see clean gaps.

// File: rtl/wmon_pkg.sv
package wmon_pkg;

  typedef enum logic [2:0] {
    WM_OFF     = 3'd0,
    WM_ABOVE   = 3'd1,
    WM_BELOW   = 3'd2,
    WM_INSIDE  = 3'd3,
    WM_INVERSE = 3'd4
  } wmon_mode_e;

  // relation of the sample to each bound
  typedef struct packed {
    logic gt_lo;
    logic lt_lo;
    logic gt_hi;
    logic lt_hi;
  } wmon_rel_t;

  localparam int unsigned WM_NUM_BOUNDS = 2;

endpackage

// File: rtl/wmon_cmp.sv
module wmon_cmp #(
  parameter int unsigned DW = 12
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sgn,
  output logic          gt,
  output logic          lt
);

  localparam int unsigned XW = DW + 1;

  // one extra bit: sign-extend when signed, zero-extend otherwise
  logic signed [XW-1:0] ax;
  logic signed [XW-1:0] bx;

  always_comb begin
    ax = {sgn & a[DW-1], a};
    bx = {sgn & b[DW-1], b};
    gt = (ax > bx);
    lt = (ax < bx);
  end

endmodule

// File: rtl/wmon_sel.sv
module wmon_sel
  import wmon_pkg::*;
(
  input  logic [2:0] mode,
  input  wmon_rel_t  rel,
  output logic       hit
);

  wmon_mode_e m;

  always_comb begin
    m = wmon_mode_e'(mode);
    case (m)
      WM_ABOVE:   hit = rel.gt_lo;
      WM_BELOW:   hit = rel.lt_hi;
      WM_INSIDE:  hit = rel.gt_lo & rel.lt_hi;
      WM_INVERSE: hit = rel.gt_hi & rel.lt_lo;
      default:    hit = 1'b0; // off and reserved codes
    endcase
  end

endmodule

// File: rtl/wmon_flags.sv
module wmon_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic eval,
  input  logic hit,
  input  logic clr,
  output logic match_o,
  output logic irq_o
);

  logic set_now;

  always_comb set_now = eval & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_o <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      match_o <= set_now;
      if (set_now)  irq_o <= 1'b1;
      else if (clr) irq_o <= 1'b0;
    end
  end

endmodule

// File: rtl/wmon_top.sv
module wmon_top
  import wmon_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  output logic          res_ready,
  input  logic [DW-1:0] res_data,
  input  logic          diff_en,
  input  logic [DW-1:0] thr_lo,
  input  logic [DW-1:0] thr_hi,
  input  logic [2:0]    mode,
  input  logic          irq_clr,
  output logic          match_o,
  output logic          irq_o
);

  logic [DW-1:0] bound [WM_NUM_BOUNDS];
  logic [WM_NUM_BOUNDS-1:0] gt_v;
  logic [WM_NUM_BOUNDS-1:0] lt_v;
  wmon_rel_t rel;
  logic hit;
  logic take;

  always_comb begin
    bound[0] = thr_lo;
    bound[1] = thr_hi;
  end

  for (genvar i = 0; i < WM_NUM_BOUNDS; i++) begin : g_cmp
    wmon_cmp #(.DW(DW)) u_cmp (
      .a  (res_data),
      .b  (bound[i]),
      .sgn(diff_en),
      .gt (gt_v[i]),
      .lt (lt_v[i])
    );
  end

  always_comb begin
    rel.gt_lo = gt_v[0];
    rel.lt_lo = lt_v[0];
    rel.gt_hi = gt_v[1];
    rel.lt_hi = lt_v[1];
    res_ready = 1'b1;
    take      = res_valid & res_ready;
  end

  wmon_sel u_sel (
    .mode(mode),
    .rel (rel),
    .hit (hit)
  );

  wmon_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .eval   (take),
    .hit    (hit),
    .clr    (irq_clr),
    .match_o(match_o),
    .irq_o  (irq_o)
  );

endmodule

// File: rtl/wmon_chk.sv
module wmon_chk #(
  parameter int unsigned DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          res_valid,
  input logic          res_ready,
  input logic [DW-1:0] res_data,
  input logic          diff_en,
  input logic [DW-1:0] thr_lo,
  input logic [DW-1:0] thr_hi,
  input logic [2:0]    mode,
  input logic          irq_clr,
  input logic          match_o,
  input logic          irq_o
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!match_o && !irq_o)); // R1
  AST_OFF_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && mode == 3'd0) |=> !match_o); // R2
  AST_ABOVE_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && mode == 3'd1 && !diff_en && res_data <= thr_lo) |=> !match_o); // R3
  AST_BELOW_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && mode == 3'd2 && !diff_en && res_data >= thr_hi) |=> !match_o); // R4
  AST_RSVD_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && mode >= 3'd5) |=> !match_o); // R7
  AST_IDLE_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> !match_o); // R8
  AST_MATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> irq_o); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr) |=> irq_o); // R9
  AST_IRQ_FALL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(irq_clr)); // R10
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready); // R12

endmodule

bind wmon_top wmon_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
  .res_data(res_data), .diff_en(diff_en), .thr_lo(thr_lo), .thr_hi(thr_hi),
  .mode(mode), .irq_clr(irq_clr), .match_o(match_o), .irq_o(irq_o)
);

// File: tb/sim_wmon_top.sv
`timescale 1ns/1ps
module sim_wmon_top;

  localparam int unsigned DW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0;
  logic res_ready;
  logic [DW-1:0] res_data = '0;
  logic diff_en = 1'b0;
  logic [DW-1:0] thr_lo = '0;
  logic [DW-1:0] thr_hi = '0;
  logic [2:0] mode = 3'd0;
  logic irq_clr = 1'b0;
  logic match_o;
  logic irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  wmon_top #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .diff_en(diff_en), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .mode(mode), .irq_clr(irq_clr), .match_o(match_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [2:0]    m;
    logic          d;
    logic [DW-1:0] x;
    logic [DW-1:0] lo;
    logic [DW-1:0] hi;
    logic          e;
    logic [3:0]    r;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{3'd1, 1'b0, 12'd101,  12'd100,  12'd0,    1'b1, 4'd3},  // R3 just above
    '{3'd1, 1'b0, 12'd100,  12'd100,  12'd0,    1'b0, 4'd3},  // R3 equal
    '{3'd2, 1'b0, 12'd199,  12'd0,    12'd200,  1'b1, 4'd4},  // R4 just below
    '{3'd2, 1'b0, 12'd200,  12'd0,    12'd200,  1'b0, 4'd4},  // R4 equal
    '{3'd3, 1'b0, 12'd150,  12'd100,  12'd200,  1'b1, 4'd5},  // R5 inside
    '{3'd3, 1'b0, 12'd200,  12'd100,  12'd200,  1'b0, 4'd5},  // R5 on upper
    '{3'd3, 1'b0, 12'd100,  12'd100,  12'd200,  1'b0, 4'd5},  // R5 on lower
    '{3'd4, 1'b0, 12'd150,  12'd200,  12'd100,  1'b1, 4'd6},  // R6 inverse inside
    '{3'd4, 1'b0, 12'd150,  12'd100,  12'd200,  1'b0, 4'd6},  // R6 normal order
    '{3'd4, 1'b0, 12'd100,  12'd200,  12'd100,  1'b0, 4'd6},  // R6 on bound
    '{3'd0, 1'b0, 12'd150,  12'd100,  12'd200,  1'b0, 4'd2},  // R2 off
    '{3'd5, 1'b0, 12'd150,  12'd100,  12'd200,  1'b0, 4'd7},  // R7
    '{3'd6, 1'b0, 12'd150,  12'd100,  12'd200,  1'b0, 4'd7},  // R7
    '{3'd7, 1'b0, 12'd150,  12'd200,  12'd100,  1'b0, 4'd7},  // R7
    '{3'd1, 1'b1, 12'hFFF,  12'h001,  12'd0,    1'b0, 4'd11}, // R11 -1 > 1 false
    '{3'd1, 1'b0, 12'hFFF,  12'h001,  12'd0,    1'b1, 4'd11}, // R11 4095 > 1
    '{3'd2, 1'b1, 12'h800,  12'd0,    12'h000,  1'b1, 4'd11}, // R11 -2048 < 0
    '{3'd3, 1'b1, 12'h000,  12'hFFF,  12'h001,  1'b1, 4'd11}  // R11 -1 < 0 < 1
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // present one sample; afterwards at the next falling edge match_o is valid
  task automatic present(input logic [2:0] m, input logic d, input logic [DW-1:0] x,
                         input logic [DW-1:0] lo, input logic [DW-1:0] hi);
    mode = m; diff_en = d; res_data = x; thr_lo = lo; thr_hi = hi;
    res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    chk(match_o == 1'b0 && irq_o == 1'b0, "R1", {match_o, irq_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(match_o == 1'b0 && irq_o == 1'b0, "R1", {match_o, irq_o}, 0);
    chk(res_ready == 1'b1, "R12", res_ready, 1);

    for (int i = 0; i < NV; i++) begin
      present(VT[i].m, VT[i].d, VT[i].x, VT[i].lo, VT[i].hi);
      chk(match_o == VT[i].e, $sformatf("R%0d vec%0d", VT[i].r, i), match_o, VT[i].e);
      chk(res_ready == 1'b1, "R12", res_ready, 1);
    end

    // clear interrupt left over from the table: R10
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(irq_o == 1'b0, "R10 clear", irq_o, 0);

    // R8: matching inputs but no valid -> no pulse, no interrupt
    mode = 3'd3; diff_en = 1'b0; res_data = 12'd150; thr_lo = 12'd100; thr_hi = 12'd200;
    @(negedge clk);
    @(negedge clk);
    chk(match_o == 1'b0, "R8 idle", match_o, 0);
    chk(irq_o == 1'b0, "R8 idle irq", irq_o, 0);

    // R8/R9: matching sample gives one-cycle pulse, irq rises together
    present(3'd3, 1'b0, 12'd150, 12'd100, 12'd200);
    chk(match_o == 1'b1, "R8 pulse", match_o, 1);
    chk(irq_o == 1'b1, "R9 set", irq_o, 1);
    @(negedge clk);
    chk(match_o == 1'b0, "R8 pulse width", match_o, 0);
    // R9 sticky across non-matching sample
    present(3'd3, 1'b0, 12'd250, 12'd100, 12'd200);
    chk(match_o == 1'b0, "R9 nomatch", match_o, 0);
    chk(irq_o == 1'b1, "R9 sticky", irq_o, 1);
    repeat (3) @(negedge clk);
    chk(irq_o == 1'b1, "R9 sticky hold", irq_o, 1);

    // R10: clear together with a matching sample -> stays set
    irq_clr = 1'b1;
    present(3'd1, 1'b0, 12'd5, 12'd4, 12'd0);
    irq_clr = 1'b0;
    chk(irq_o == 1'b1, "R10 set wins", irq_o, 1);
    // R10: clear together with a non-matching sample -> clears
    irq_clr = 1'b1;
    present(3'd1, 1'b0, 12'd4, 12'd4, 12'd0);
    irq_clr = 1'b0;
    chk(irq_o == 1'b0, "R10 clear", irq_o, 0);

    // R11 extremes: unsigned max vs min
    present(3'd2, 1'b0, 12'h800, 12'd0, 12'h7FF);
    chk(match_o == 1'b0, "R11 unsigned 2048<2047", match_o, 0);
    present(3'd2, 1'b1, 12'h800, 12'd0, 12'h7FF);
    chk(match_o == 1'b1, "R11 signed -2048<2047", match_o, 1);

    // R2: off mode with a sample that would match every other mode
    present(3'd0, 1'b0, 12'd150, 12'd100, 12'd200);
    chk(match_o == 1'b0, "R2 off", match_o, 0);

    // R1: reset in the middle clears both flags
    present(3'd1, 1'b0, 12'd9, 12'd1, 12'd0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(match_o == 1'b0 && irq_o == 1'b0, "R1 rereset", {match_o, irq_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule